// File: doc/BRIEF.md
# Reorder Buffer with Precise Faults

This block keeps the speculative results of an out-of-order core in program order. Each instruction that is dispatched takes the entry at the tail of a circular queue, which records its PC and its destination register. The index of that entry is returned as the rename tag. Execution units may write results back in any order. A writeback names an entry by its tag and stores a data value, a fault flag and, for branches, a mispredict flag with the corrected target.

Operand lookups search the live entries for the youngest one that writes the requested register. The block returns that entry's tag, its readiness and its value. When no live entry names the register, the value comes from the architectural register file held inside the block.

Retirement takes place only at the head, and only when the head entry is done. A clean head writes its value into the register file. A faulting head writes nothing. It redirects fetch to a fixed handler vector and squashes every entry. A mispredicted branch at the head retires its own result, redirects to the corrected target and squashes everything younger.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `ret_valid` and `rdr_valid` are 0, and every register reads 0 with `lk_hit` low.
- R2: An accepted dispatch is given the tag `disp_tag`, which equals the tail index. Successive dispatches get consecutive tags modulo DEPTH.
- R3: With DEPTH entries live, `disp_ready` is 0. A dispatch offered in that state is dropped: no entry is allocated and the tail does not move.
- R4: A writeback stores its value in the tagged entry and marks the entry ready. Writebacks may arrive in any order. A lookup that hits an entry not yet ready returns `lk_hit`=1, `lk_ready`=0 and that entry's tag.
- R5: When several live entries write the same register, a lookup returns the youngest of them.
- R6: A lookup that matches no live entry returns `lk_hit`=0, `lk_ready`=1 and the register file value.
- R7: Retirement is in order. While the head entry is not ready, `ret_valid` stays 0 even if younger entries are ready. A retirement shows `ret_dst`, `ret_value` and `head_pc` for one cycle, and writes the value into the register file.
- R8: A done head whose fault flag is set does not retire. It raises `rdr_valid` for one cycle with `rdr_pc` equal to HANDLER_VEC. It leaves the register file unchanged and empties the buffer, and the tail returns to 0.
- R9: A done head whose mispredict flag is set retires its own value (`ret_valid`=1). In the same cycle it raises `rdr_valid` with `rdr_pc` equal to its stored target, and all younger entries are squashed.
- R10: During a redirect cycle `disp_ready` is 0 and a dispatch offered then is dropped. The flush wins, and afterwards head, tail and count are all 0.
- R11: With FORWARD_WB set, a writeback to the entry that the current lookup hits is returned in the same cycle, with `lk_ready`=1 and the new value.
- R12: A writeback whose tag names an entry that is not allocated is ignored. An entry allocated at that index later still starts out not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_dst | input | REG_W | Destination register of the dispatched instruction |
| disp_ready | output | 1 | Dispatch will be accepted this cycle |
| disp_tag | output | TAG_W | Tag given to a dispatch this cycle (tail index) |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TAG_W | Entry written back |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Instruction raised a fault |
| wb_mispredict | input | 1 | Branch was mispredicted |
| wb_target | input | PC_W | Corrected branch target |
| lk_reg | input | REG_W | Register being looked up |
| lk_hit | output | 1 | A live entry writes lk_reg |
| lk_ready | output | 1 | Returned value is usable |
| lk_tag | output | TAG_W | Tag of the youngest matching entry |
| lk_value | output | DATA_W | Operand value |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_dst | output | REG_W | Register written by the retirement |
| ret_value | output | DATA_W | Value written by the retirement |
| head_pc | output | PC_W | PC of the head entry |
| rdr_valid | output | 1 | Fetch redirect and flush this cycle |
| rdr_pc | output | PC_W | Redirect target |

## Verification
The assertions assume that writebacks name entries already handed out and that each allocation is written back at most once. They also assume the mispredict flag arrives only with a meaningful target. The stimulus writes each tag once after its dispatch and sets the mispredict flag on only one branch. The single deliberate writeback to a free index is sent while the buffer is empty. Dispatches at the full limit and during a redirect are offered on purpose, because the pointer properties are meant to hold across exactly those dropped requests.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      HEAD_WAIT       = 2'd0,
      HEAD_RETIRE     = 2'd1,
      HEAD_FAULT      = 2'd2,
      HEAD_MISPREDICT = 2'd3
   } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head  <= head + TAG_W'(pop);
         tail  <= tail + TAG_W'(push);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/rob_search.sv
module rob_search #(
   parameter int DEPTH = 8,
   parameter int REG_W = 5,
   parameter int DATA_W = 32,
   parameter bit FORWARD_WB = 1'b1,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [TAG_W-1:0]             head,
   input  logic [CNT_W-1:0]             count,
   input  logic [DEPTH-1:0]             e_valid,
   input  logic [DEPTH-1:0]             e_ready,
   input  logic [DEPTH-1:0][REG_W-1:0]  e_dst,
   input  logic [DEPTH-1:0][DATA_W-1:0] e_val,
   input  logic [REG_W-1:0]             lk_reg,
   input  logic                         wb_valid,
   input  logic [TAG_W-1:0]             wb_tag,
   input  logic [DATA_W-1:0]            wb_value,
   output logic                         hit,
   output logic                         hit_ready,
   output logic [TAG_W-1:0]             hit_tag,
   output logic [DATA_W-1:0]            hit_value
);
   logic             base_ready;
   logic [DATA_W-1:0] base_value;

   // Walk from oldest to youngest; the last match is the youngest producer.
   always_comb begin
      logic [TAG_W-1:0] idx;
      hit     = 1'b0;
      hit_tag = '0;
      idx     = '0;
      for (int i = 0; i < DEPTH; i++) begin
         idx = head + TAG_W'(i);
         if (CNT_W'(i) < count && e_valid[idx] && e_dst[idx] == lk_reg) begin
            hit     = 1'b1;
            hit_tag = idx;
         end
      end
   end

   assign base_ready = e_ready[hit_tag];
   assign base_value = e_val[hit_tag];

   generate
      if (FORWARD_WB) begin : g_fwd
         logic bypass;
         assign bypass    = hit && wb_valid && (wb_tag == hit_tag);
         assign hit_ready = bypass ? 1'b1 : base_ready;
         assign hit_value = bypass ? wb_value : base_value;
      end else begin : g_nofwd
         logic [DATA_W-1:0] unused_wb;
         assign unused_wb = wb_value ^ {{(DATA_W-1){1'b0}}, wb_valid ^ (^wb_tag)};
         assign hit_ready = base_ready;
         assign hit_value = base_value;
      end
   endgenerate
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH = 8,
   parameter int PC_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_W = 5,
   parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(32'h0000_0080),
   parameter bit FORWARD_WB = 1'b1,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int NREGS = 1 << REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [PC_W-1:0]   disp_pc,
   input  logic [REG_W-1:0]  disp_dst,
   output logic              disp_ready,
   output logic [TAG_W-1:0]  disp_tag,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic              wb_fault,
   input  logic              wb_mispredict,
   input  logic [PC_W-1:0]   wb_target,
   input  logic [REG_W-1:0]  lk_reg,
   output logic              lk_hit,
   output logic              lk_ready,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [DATA_W-1:0] lk_value,
   output logic              ret_valid,
   output logic [REG_W-1:0]  ret_dst,
   output logic [DATA_W-1:0] ret_value,
   output logic [PC_W-1:0]   head_pc,
   output logic              rdr_valid,
   output logic [PC_W-1:0]   rdr_pc
);
   import rob_pkg::*;

   generate
      if (DEPTH < 2 || (1 << TAG_W) != DEPTH) begin : g_bad_depth
         $error("rob_core: DEPTH must be a power of two of at least 2");
      end
      if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
         $error("rob_core: REG_W must lie between 1 and 8");
      end
   endgenerate

   logic [DEPTH-1:0]             e_valid, e_ready, e_fault, e_misp;
   logic [DEPTH-1:0][PC_W-1:0]   e_pc, e_tgt;
   logic [DEPTH-1:0][REG_W-1:0]  e_dst;
   logic [DEPTH-1:0][DATA_W-1:0] e_val;
   logic [NREGS-1:0][DATA_W-1:0] arf;

   logic [TAG_W-1:0] q_head, q_tail;
   logic [CNT_W-1:0] q_cnt;
   logic             q_full, q_empty;
   logic             do_push, do_pop, do_flush;
   head_act_e        head_act;

   logic              s_hit, s_ready;
   logic [TAG_W-1:0]  s_tag;
   logic [DATA_W-1:0] s_value;

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .flush(do_flush),
      .head(q_head), .tail(q_tail), .count(q_cnt), .full(q_full), .empty(q_empty)
   );

   rob_search #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .FORWARD_WB(FORWARD_WB)) u_search (
      .head(q_head), .count(q_cnt), .e_valid(e_valid), .e_ready(e_ready),
      .e_dst(e_dst), .e_val(e_val), .lk_reg(lk_reg),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .hit(s_hit), .hit_ready(s_ready), .hit_tag(s_tag), .hit_value(s_value)
   );

   // Head decision: faults win over mispredicts, both only once done.
   always_comb begin
      head_act = HEAD_WAIT;
      if (e_valid[q_head] && e_ready[q_head]) begin
         if (e_fault[q_head])     head_act = HEAD_FAULT;
         else if (e_misp[q_head]) head_act = HEAD_MISPREDICT;
         else                     head_act = HEAD_RETIRE;
      end
   end

   assign ret_valid = (head_act == HEAD_RETIRE) || (head_act == HEAD_MISPREDICT);
   assign rdr_valid = (head_act == HEAD_FAULT) || (head_act == HEAD_MISPREDICT);
   assign rdr_pc    = (head_act == HEAD_FAULT) ? HANDLER_VEC : e_tgt[q_head];
   assign ret_dst   = e_dst[q_head];
   assign ret_value = e_val[q_head];
   assign head_pc   = e_pc[q_head];

   assign do_flush   = rdr_valid;
   assign do_pop     = ret_valid;
   assign disp_ready = !q_full && !do_flush;
   assign do_push    = disp_valid && disp_ready;
   assign disp_tag   = q_tail;

   assign lk_hit   = s_hit;
   assign lk_tag   = s_tag;
   assign lk_ready = s_hit ? s_ready : 1'b1;
   assign lk_value = s_hit ? s_value : arf[lk_reg];

   always_ff @(posedge clk) begin
      if (!rst_n || do_flush) begin
         e_valid <= '0;
         e_ready <= '0;
         e_fault <= '0;
         e_misp  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_pop && q_head == TAG_W'(i)) begin
               e_valid[i] <= 1'b0;
            end
            if (wb_valid && wb_tag == TAG_W'(i) && e_valid[i]) begin
               e_ready[i] <= 1'b1;
               e_fault[i] <= wb_fault;
               e_misp[i]  <= wb_mispredict;
            end
            if (do_push && q_tail == TAG_W'(i)) begin
               e_valid[i] <= 1'b1;
               e_ready[i] <= 1'b0;
               e_fault[i] <= 1'b0;
               e_misp[i]  <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (do_push && q_tail == TAG_W'(i)) begin
            e_pc[i]  <= disp_pc;
            e_dst[i] <= disp_dst;
         end
         if (wb_valid && wb_tag == TAG_W'(i) && e_valid[i]) begin
            e_val[i] <= wb_value;
            e_tgt[i] <= wb_target;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arf <= '0;
      end else if (ret_valid) begin
         arf[ret_dst] <= ret_value;
      end
   end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 3,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TAG_W-1:0] head,
   input logic [TAG_W-1:0] tail,
   input logic [CNT_W-1:0] count,
   input logic             full,
   input logic             empty,
   input logic             push,
   input logic             pop,
   input logic             flush,
   input logic             ret_valid,
   input logic             rdr_valid
);
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   p_full_holds_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !flush) |=> $stable(tail));

   p_alloc_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |=> tail == $past(tail) + TAG_W'(1));

   p_retire_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> !empty);

   p_redirect_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdr_valid |=> !rdr_valid);

   p_flush_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rdr_valid |=> (count == '0 && head == '0 && tail == '0));
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .head(q_head), .tail(q_tail), .count(q_cnt),
   .full(q_full), .empty(q_empty), .push(do_push), .pop(do_pop),
   .flush(do_flush), .ret_valid(ret_valid), .rdr_valid(rdr_valid)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/100ps
module rob_core_tb;
   localparam logic [31:0] HVEC = 32'h0000_0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 1'b0;
   logic [31:0] disp_pc = '0;
   logic [4:0]  disp_dst = '0;
   logic        disp_ready;
   logic [2:0]  disp_tag;
   logic        wb_valid = 1'b0;
   logic [2:0]  wb_tag = '0;
   logic [31:0] wb_value = '0;
   logic        wb_fault = 1'b0;
   logic        wb_mispredict = 1'b0;
   logic [31:0] wb_target = '0;
   logic [4:0]  lk_reg = '0;
   logic        lk_hit, lk_ready;
   logic [2:0]  lk_tag;
   logic [31:0] lk_value;
   logic        ret_valid;
   logic [4:0]  ret_dst;
   logic [31:0] ret_value;
   logic [31:0] head_pc;
   logic        rdr_valid;
   logic [31:0] rdr_pc;

   int checks = 0;
   int failures = 0;

   typedef struct packed {
      logic [4:0]  dst;
      logic [31:0] val;
      logic [31:0] pc;
   } ret_t;
   ret_t        exp_q[$];
   logic [31:0] rdr_q[$];

   always #2 clk = ~clk;

   rob_core #(.HANDLER_VEC(HVEC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_dst(disp_dst),
      .disp_ready(disp_ready), .disp_tag(disp_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .wb_fault(wb_fault), .wb_mispredict(wb_mispredict), .wb_target(wb_target),
      .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_tag(lk_tag),
      .lk_value(lk_value), .ret_valid(ret_valid), .ret_dst(ret_dst),
      .ret_value(ret_value), .head_pc(head_pc), .rdr_valid(rdr_valid), .rdr_pc(rdr_pc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      disp_valid = 1'b0;
      wb_valid = 1'b0;
      wb_fault = 1'b0;
      wb_mispredict = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clear_in();
      end
   endtask

   task automatic dispatch(input logic [31:0] pc, input logic [4:0] dst, input logic [2:0] exp_tag);
      @(negedge clk);
      clear_in();
      disp_valid = 1'b1;
      disp_pc = pc;
      disp_dst = dst;
      #1;
      chk("R2 tag", {29'b0, disp_tag}, {29'b0, exp_tag});
      chk("R2 ready", {31'b0, disp_ready}, 32'd1);
   endtask

   task automatic wb(input logic [2:0] tag, input logic [31:0] val, input logic flt,
                     input logic misp, input logic [31:0] tgt);
      @(negedge clk);
      clear_in();
      wb_valid = 1'b1;
      wb_tag = tag;
      wb_value = val;
      wb_fault = flt;
      wb_mispredict = misp;
      wb_target = tgt;
   endtask

   task automatic look(input string req, input logic [4:0] r, input logic hit,
                       input logic rdy, input logic [2:0] tag, input logic [31:0] val);
      lk_reg = r;
      #1;
      chk({req, " hit"}, {31'b0, lk_hit}, {31'b0, hit});
      chk({req, " ready"}, {31'b0, lk_ready}, {31'b0, rdy});
      if (hit) chk({req, " tag"}, {29'b0, lk_tag}, {29'b0, tag});
      if (rdy) chk({req, " value"}, lk_value, val);
   endtask

   task automatic expect_ret(input logic [4:0] dst, input logic [31:0] val, input logic [31:0] pc);
      exp_q.push_back('{dst: dst, val: val, pc: pc});
   endtask

   // Monitor: pops expected retirements and redirects as they appear.
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (ret_valid) begin
            if (exp_q.size() == 0) begin
               chk("R7 unexpected retire", {27'b0, ret_dst}, 32'hFFFF_FFFF);
            end else begin
               ret_t e;
               e = exp_q.pop_front();
               chk("R7 ret_dst", {27'b0, ret_dst}, {27'b0, e.dst});
               chk("R7 ret_value", ret_value, e.val);
               chk("R7 head_pc", head_pc, e.pc);
            end
         end
         if (rdr_valid) begin
            if (rdr_q.size() == 0) begin
               chk("R8 unexpected redirect", rdr_pc, 32'hFFFF_FFFF);
            end else begin
               logic [31:0] t;
               t = rdr_q.pop_front();
               if (t == HVEC) chk("R8 rdr_pc", rdr_pc, t);
               else           chk("R9 rdr_pc", rdr_pc, t);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R6 fallback to the register file
      @(negedge clk);
      look("R1", 5'd3, 1'b0, 1'b1, 3'd0, 32'd0);
      chk("R1 disp_ready", {31'b0, disp_ready}, 32'd1);
      chk("R1 disp_tag", {29'b0, disp_tag}, 32'd0);
      chk("R1 ret_valid", {31'b0, ret_valid}, 32'd0);
      chk("R1 rdr_valid", {31'b0, rdr_valid}, 32'd0);

      // R4 R5 R7 R11: two writers of r3, one of r4, out-of-order writeback
      expect_ret(5'd3, 32'd7, 32'h100);
      expect_ret(5'd3, 32'd11, 32'h104);
      expect_ret(5'd4, 32'd5, 32'h108);
      dispatch(32'h100, 5'd3, 3'd0);
      dispatch(32'h104, 5'd3, 3'd1);
      dispatch(32'h108, 5'd4, 3'd2);
      @(negedge clk);
      clear_in();
      look("R5", 5'd3, 1'b1, 1'b0, 3'd1, 32'd0);
      wb(3'd1, 32'd11, 1'b0, 1'b0, 32'd0);
      look("R11", 5'd3, 1'b1, 1'b1, 3'd1, 32'd11);
      @(negedge clk);
      clear_in();
      look("R4", 5'd3, 1'b1, 1'b1, 3'd1, 32'd11);
      wb(3'd2, 32'd5, 1'b0, 1'b0, 32'd0);
      #1;
      chk("R7 head waits", {31'b0, ret_valid}, 32'd0);
      wb(3'd0, 32'd7, 1'b0, 1'b0, 32'd0);
      idle(5);
      look("R6 r3", 5'd3, 1'b0, 1'b1, 3'd0, 32'd11);
      look("R6 r4", 5'd4, 1'b0, 1'b1, 3'd0, 32'd5);

      // R3 full: head and tail both at 3
      for (int i = 0; i < 8; i++) expect_ret(5'(10 + i), 32'(100 + i), 32'(32'h200 + 4 * i));
      for (int i = 0; i < 8; i++) dispatch(32'(32'h200 + 4 * i), 5'(10 + i), 3'((3 + i) % 8));
      @(negedge clk);
      clear_in();
      #1;
      chk("R3 full ready", {31'b0, disp_ready}, 32'd0);
      @(negedge clk);
      clear_in();
      disp_valid = 1'b1;
      disp_pc = 32'h2F0;
      disp_dst = 5'd31;
      #1;
      chk("R3 refused", {31'b0, disp_ready}, 32'd0);
      wb(3'd3, 32'd100, 1'b0, 1'b0, 32'd0);
      idle(1);
      @(negedge clk);
      #1;
      chk("R3 ready after retire", {31'b0, disp_ready}, 32'd1);
      chk("R3 tail unmoved", {29'b0, disp_tag}, 32'd3);
      for (int i = 1; i < 8; i++) wb(3'((3 + i) % 8), 32'(100 + i), 1'b0, 1'b0, 32'd0);
      idle(10);
      look("R7 r17", 5'd17, 1'b0, 1'b1, 3'd0, 32'd107);
      look("R3 r31", 5'd31, 1'b0, 1'b1, 3'd0, 32'd0);

      // R12 writeback to a free index, then allocate that index
      wb(3'd5, 32'd999, 1'b0, 1'b0, 32'd0);
      expect_ret(5'd21, 32'd21, 32'h280);
      expect_ret(5'd22, 32'd22, 32'h284);
      expect_ret(5'd23, 32'd23, 32'h288);
      dispatch(32'h280, 5'd21, 3'd3);
      dispatch(32'h284, 5'd22, 3'd4);
      dispatch(32'h288, 5'd23, 3'd5);
      @(negedge clk);
      clear_in();
      look("R12", 5'd23, 1'b1, 1'b0, 3'd5, 32'd0);
      wb(3'd3, 32'd21, 1'b0, 1'b0, 32'd0);
      wb(3'd4, 32'd22, 1'b0, 1'b0, 32'd0);
      wb(3'd5, 32'd23, 1'b0, 1'b0, 32'd0);
      idle(5);
      look("R12 drained", 5'd23, 1'b0, 1'b1, 3'd0, 32'd23);

      // R8 fault at head: tags 6, 7, 0
      expect_ret(5'd24, 32'd1, 32'h300);
      rdr_q.push_back(HVEC);
      dispatch(32'h300, 5'd24, 3'd6);
      dispatch(32'h304, 5'd25, 3'd7);
      dispatch(32'h308, 5'd26, 3'd0);
      wb(3'd6, 32'd1, 1'b0, 1'b0, 32'd0);
      wb(3'd7, 32'd2, 1'b1, 1'b0, 32'd0);
      wb(3'd0, 32'd3, 1'b0, 1'b0, 32'd0);
      #1;
      chk("R8 no retire on fault", {31'b0, ret_valid}, 32'd0);
      idle(3);
      look("R8 r24", 5'd24, 1'b0, 1'b1, 3'd0, 32'd1);
      look("R8 r25", 5'd25, 1'b0, 1'b1, 3'd0, 32'd0);
      look("R8 r26", 5'd26, 1'b0, 1'b1, 3'd0, 32'd0);
      chk("R8 tail reset", {29'b0, disp_tag}, 32'd0);

      // R9 mispredict at head, R10 dispatch in the redirect cycle
      expect_ret(5'd27, 32'h55, 32'h400);
      rdr_q.push_back(32'h800);
      dispatch(32'h400, 5'd27, 3'd0);
      dispatch(32'h404, 5'd28, 3'd1);
      wb(3'd1, 32'd8, 1'b0, 1'b0, 32'd0);
      wb(3'd0, 32'h55, 1'b0, 1'b1, 32'h800);
      @(negedge clk);
      clear_in();
      disp_valid = 1'b1;
      disp_pc = 32'h408;
      disp_dst = 5'd29;
      #1;
      chk("R9 redirect", {31'b0, rdr_valid}, 32'd1);
      chk("R9 branch retires", {31'b0, ret_valid}, 32'd1);
      chk("R10 blocked", {31'b0, disp_ready}, 32'd0);
      idle(3);
      look("R9 r27", 5'd27, 1'b0, 1'b1, 3'd0, 32'h55);
      look("R9 r28", 5'd28, 1'b0, 1'b1, 3'd0, 32'd0);
      look("R10 r29", 5'd29, 1'b0, 1'b1, 3'd0, 32'd0);
      chk("R10 tail reset", {29'b0, disp_tag}, 32'd0);
      chk("R10 ready", {31'b0, disp_ready}, 32'd1);

      idle(2);
      chk("R7 retire queue drained", exp_q.size(), 32'd0);
      chk("R8 redirect queue drained", rdr_q.size(), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule